// File: doc/BRIEF.md
# Serial Video Channel Coder with Run-Length Watch

This block turns one 10-bit parallel video word per word clock into ten channel-coded bits, ready for a downstream serializer that sends bit 0 first. Each data bit first goes through a self-synchronizing scrambler built on the polynomial X^9 + X^4 + 1. The scrambled bit then goes through an NRZI stage (X + 1), where a one toggles the line level and a zero holds it. The block handles all ten bits of a word in one cycle. Bit i sees the scrambler history that bits 0 to i-1 of the same word have already updated.

The scrambler history runs without a break across words and lines. Only the block reset clears it, and nothing in the data path does. For test, the history can be read out and can be preloaded. A monitor follows the coded bit stream across word boundaries and holds the longest run of equal output bits seen since the last clear. The count saturates. The monitor also raises an alert once that run reaches the length that marks the known stress patterns. A stream of alternating 300h/198h words gives 19 bits of one level and 1 of the other. A stream of alternating 200h/110h words gives 20 bits of each level.

Top module: `sdi_chan_enc`

## Requirements
- R1: A synchronous active-high reset sets the coded output, the scrambler history, the line level, the longest-run count and the alert to zero.
- R2: For each bit, LSB first, the scrambled bit is the data bit XOR the scrambled bit 9 positions earlier XOR the scrambled bit 4 positions earlier. The history is kept across words. `scr_state_o` bit k holds the scrambled bit k+1 positions back, so bit 0 is the most recent one.
- R3: Each coded bit is the scrambled bit XOR the previous coded bit, and this also holds across word boundaries. `code_o` shows the coded bits of a word in the cycle after that word is presented (bit 0 is sent first). From reset, word 001h gives code 10Fh and history 023h.
- R4: While `load_i` is high, the scrambler history takes `load_state_i`. The word on the input is ignored, and `code_o`, the line level and the run monitor keep their values.
- R5: `max_run_o` is the longest run of equal coded bits since reset or the last clear, counted across word boundaries. It saturates at 255.
- R6: `alert_o` is high exactly when `max_run_o` is 19 or more.
- R7: `clr_i` restarts the run count and the maximum before the word of the same cycle is counted. It also drops the alert.
- R8: With a continuous stream of alternating 300h/198h words, some scrambler starting states produce a longest run of exactly 19.
- R9: With a continuous stream of alternating 200h/110h words, some scrambler starting states produce a longest run of exactly 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 10 | Parallel video word |
| load_i | input | 1 | Preload scrambler history this cycle |
| load_state_i | input | 9 | Value for the preload |
| clr_i | input | 1 | Restart the run monitor |
| code_o | output | 10 | Coded bits, bit 0 sent first |
| scr_state_o | output | 9 | Scrambler history, bit 0 most recent |
| max_run_o | output | 8 | Longest equal-bit run since clear |
| alert_o | output | 1 | Longest run at or above 19 |

## Verification
Every cycle, the assertions check the preload and hold behaviour, the reset values, that the maximum only grows between clears, that after a clear it is no more than one word long, and that the alert never rises below the threshold. Only the bench scenarios can show that the scrambled and NRZI bits are correct. The bench compares them word by word against a bit-serial model. It sweeps all 512 starting states to show that the 19/1 and 20/20 stress patterns appear. A long all-zero stream shows that the count saturates.

// File: rtl/sdi_enc_pkg.sv
package sdi_enc_pkg;
  localparam int WORD_W_D  = 10;
  localparam int SCR_W_D   = 9;
  localparam int SCR_TAP_D = 4;
  localparam int RUN_W_D   = 8;
  localparam int ALERT_D   = 19;
endpackage

// File: rtl/sdi_scr_nrzi.sv
module sdi_scr_nrzi #(
  parameter int WORD_W  = sdi_enc_pkg::WORD_W_D,
  parameter int SCR_W   = sdi_enc_pkg::SCR_W_D,
  parameter int SCR_TAP = sdi_enc_pkg::SCR_TAP_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  input  logic [SCR_W-1:0]  load_state_i,
  output logic [WORD_W-1:0] code_nxt_o,
  output logic [WORD_W-1:0] code_o,
  output logic [SCR_W-1:0]  state_o
);
  localparam int HI = SCR_W - 1;
  localparam int LO = SCR_TAP - 1;

  logic [SCR_W-1:0] state_q;
  logic             lvl_q;
  logic [WORD_W-1:0] code_q;

  logic [SCR_W-1:0] hist [0:WORD_W];
  logic             lvl  [0:WORD_W];
  logic [WORD_W-1:0] scr;

  assign hist[0] = state_q;
  assign lvl[0]  = lvl_q;

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      assign scr[i]      = word_i[i] ^ hist[i][HI] ^ hist[i][LO];
      assign hist[i+1]   = {hist[i][SCR_W-2:0], scr[i]};
      assign lvl[i+1]    = lvl[i] ^ scr[i];
      assign code_nxt_o[i] = lvl[i+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      lvl_q   <= 1'b0;
      code_q  <= '0;
    end else if (load_i) begin
      state_q <= load_state_i;
    end else begin
      state_q <= hist[WORD_W];
      lvl_q   <= lvl[WORD_W];
      code_q  <= code_nxt_o;
    end
  end

  assign code_o  = code_q;
  assign state_o = state_q;

  assert_preload_R4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (state_o == $past(load_state_i)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    load_i |=> $stable(code_o));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (code_o == '0 && state_o == '0));
endmodule

// File: rtl/sdi_run_mon.sv
module sdi_run_mon #(
  parameter int WORD_W = sdi_enc_pkg::WORD_W_D,
  parameter int RUN_W  = sdi_enc_pkg::RUN_W_D,
  parameter int ALERT  = sdi_enc_pkg::ALERT_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [WORD_W-1:0] bits_i,
  output logic [RUN_W-1:0]  max_o,
  output logic              alert_o
);
  localparam logic [RUN_W-1:0] SAT = {RUN_W{1'b1}};
  localparam logic [RUN_W-1:0] ONE = RUN_W'(1);
  localparam logic [RUN_W-1:0] THR = RUN_W'(ALERT);

  logic [RUN_W-1:0] run_q, max_q;
  logic             lvl_q, alert_q;

  logic [RUN_W-1:0] run [0:WORD_W];
  logic [RUN_W-1:0] mx  [0:WORD_W];
  logic             lv  [0:WORD_W];

  assign run[0] = clr_i ? '0 : run_q;
  assign mx[0]  = clr_i ? '0 : max_q;
  assign lv[0]  = lvl_q;

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      assign run[i+1] = (bits_i[i] == lv[i]) ?
                        ((run[i] == SAT) ? SAT : run[i] + ONE) : ONE;
      assign lv[i+1]  = bits_i[i];
      assign mx[i+1]  = (run[i+1] > mx[i]) ? run[i+1] : mx[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      max_q   <= '0;
      lvl_q   <= 1'b0;
      alert_q <= 1'b0;
    end else if (en_i) begin
      run_q   <= run[WORD_W];
      max_q   <= mx[WORD_W];
      lvl_q   <= lv[WORD_W];
      alert_q <= (mx[WORD_W] >= THR);
    end else if (clr_i) begin
      run_q   <= '0;
      max_q   <= '0;
      alert_q <= 1'b0;
    end
  end

  assign max_o   = max_q;
  assign alert_o = alert_q;

  assert_max_grows_R5: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (max_o >= $past(max_o)));
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (max_o <= RUN_W'(WORD_W)));
  assert_alert_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_o) |-> (max_o >= THR));
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (max_o == '0 && !alert_o));
endmodule

// File: rtl/sdi_chan_enc.sv
module sdi_chan_enc #(
  parameter int WORD_W  = sdi_enc_pkg::WORD_W_D,
  parameter int SCR_W   = sdi_enc_pkg::SCR_W_D,
  parameter int SCR_TAP = sdi_enc_pkg::SCR_TAP_D,
  parameter int RUN_W   = sdi_enc_pkg::RUN_W_D,
  parameter int ALERT   = sdi_enc_pkg::ALERT_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  input  logic [SCR_W-1:0]  load_state_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] code_o,
  output logic [SCR_W-1:0]  scr_state_o,
  output logic [RUN_W-1:0]  max_run_o,
  output logic              alert_o
);
  logic [WORD_W-1:0] code_nxt;

  sdi_scr_nrzi #(.WORD_W(WORD_W), .SCR_W(SCR_W), .SCR_TAP(SCR_TAP)) u_coder (
    .clk(clk), .rst(rst), .word_i(word_i), .load_i(load_i),
    .load_state_i(load_state_i), .code_nxt_o(code_nxt),
    .code_o(code_o), .state_o(scr_state_o)
  );

  sdi_run_mon #(.WORD_W(WORD_W), .RUN_W(RUN_W), .ALERT(ALERT)) u_mon (
    .clk(clk), .rst(rst), .en_i(!load_i), .clr_i(clr_i),
    .bits_i(code_nxt), .max_o(max_run_o), .alert_o(alert_o)
  );
endmodule

// File: tb/tb_sdi_chan_enc.sv
module tb_sdi_chan_enc;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] VEC [16] = '{10'h040, 10'h200, 10'h3AC, 10'h004,
    10'h155, 10'h2AA, 10'h1F0, 10'h00F, 10'h300, 10'h198, 10'h110, 10'h3FB,
    10'h080, 10'h123, 10'h2DE, 10'h007};

  logic clk = 0, rst = 0, load = 0, clr = 0;
  logic [9:0] word = '0;
  logic [8:0] lstate = '0;
  logic [9:0] code;
  logic [8:0] sst;
  logic [7:0] maxr;
  logic alert;

  int n_tests = 0, n_fail = 0;
  logic [8:0] mq; logic ml; int mrun, mmax; logic [9:0] exp_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdi_chan_enc dut (.clk(clk), .rst(rst), .word_i(word), .load_i(load),
    .load_state_i(lstate), .clr_i(clr), .code_o(code), .scr_state_o(sst),
    .max_run_o(maxr), .alert_o(alert));

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic model_word(input logic [9:0] w, input logic c);
    logic s;
    if (c) begin mrun = 0; mmax = 0; end
    for (int i = 0; i < 10; i++) begin
      s = w[i] ^ mq[8] ^ mq[3];
      mq = {mq[7:0], s};
      ml = ml ^ s;
      exp_code[i] = ml;
      if (!s) mrun = (mrun >= 255) ? 255 : mrun + 1; else mrun = 1;
      if (mrun > mmax) mmax = mrun;
    end
  endtask

  task automatic step(input logic [9:0] w, input logic ld, input logic [8:0] ls, input logic c);
    @(negedge clk);
    word = w; load = ld; lstate = ls; clr = c;
    if (ld) begin
      mq = ls;
      if (c) begin mrun = 0; mmax = 0; end
    end else model_word(w, c);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; load = 0; clr = 0; word = '0;
    repeat (3) @(posedge clk);
    #1; rst = 0;
    mq = '0; ml = 0; mrun = 0; mmax = 0; exp_code = '0;
  endtask

  function automatic int alert_exp();
    return (mmax >= 19) ? 1 : 0;
  endfunction

  task automatic sweep(input logic [9:0] a, input logic [9:0] b, input int want,
                       input string req);
    int found = 0;
    int bad = 0;
    for (int st = 0; st < 512; st++) begin
      step(10'h000, 1, st[8:0], 0);
      for (int k = 0; k < 26; k++) begin
        step((k % 2 == 0) ? a : b, 0, 9'h0, k == 6);
        if (code !== exp_code) bad++;
      end
      if (maxr != mmax[7:0]) bad++;
      if (maxr == want[7:0] && alert == 1'b1) found++;
    end
    chk({req, " coded stream and run match model"}, bad, 0);
    chk({req, " stress run length reached"}, (found > 0) ? 1 : 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset values
    chk("R1 code", code, 0); chk("R1 state", sst, 0);
    chk("R1 max", maxr, 0); chk("R1 alert", alert, 0);

    // R3 / R2 hand-computed vector from reset
    step(10'h001, 0, 9'h0, 0);
    chk("R3 code 001h", code, 10'h10F);
    chk("R2 state after 001h", sst, 9'h023);
    chk("R5 max after 001h", maxr, 4);

    // Vector table walk against bit-serial model
    foreach (VEC[j]) begin
      step(VEC[j], 0, 9'h0, 0);
      chk("R3 table code", code, exp_code);
      chk("R2 table state", sst, mq);
      chk("R5 table max", maxr, mmax);
    end

    // R4 preload: word ignored, outputs hold
    begin
      logic [9:0] c0; logic [7:0] m0;
      c0 = code; m0 = maxr;
      step(10'h3FF, 1, 9'h1A5, 0);
      chk("R4 state loaded", sst, 9'h1A5);
      chk("R4 code held", code, c0);
      chk("R4 max held", maxr, m0);
      step(10'h2C4, 0, 9'h0, 0);
      chk("R4 code after preload", code, exp_code);
      chk("R2 state after preload", sst, mq);
    end

    // R6 boundary and R5 saturation with a zero stream from reset
    do_reset();
    step(10'h000, 0, 9'h0, 0);
    chk("R6 max 10", maxr, 10); chk("R6 alert low below 19", alert, 0);
    step(10'h000, 0, 9'h0, 0);
    chk("R6 max 20", maxr, 20); chk("R6 alert high at 20", alert, 1);
    repeat (28) step(10'h000, 0, 9'h0, 0);
    chk("R5 saturate", maxr, 255); chk("R6 alert saturated", alert, alert_exp());

    // R7 clear restarts counting with word in same cycle
    step(10'h000, 0, 9'h0, 1);
    chk("R7 max after clear", maxr, 10); chk("R7 alert after clear", alert, 0);
    step(10'h000, 1, 9'h055, 1);
    chk("R7 clear during preload", maxr, 0);

    // R1 reset in the middle of activity
    step(10'h2AB, 0, 9'h0, 0);
    do_reset();
    chk("R1 code mid", code, 0); chk("R1 state mid", sst, 0);
    chk("R1 max mid", maxr, 0);

    // R8 / R9 stress patterns over all starting states
    sweep(10'h300, 10'h198, 19, "R8");
    sweep(10'h200, 10'h110, 20, "R9");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule